// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that fetches, decodes and retires one instruction in every clock cycle. It covers a compact load/store subset: five register-register operations (add, subtract, AND, OR, signed set-if-less), an OR with a zero-extended immediate, a word load, a word store and a branch taken when two registers are equal. The program counter, a 32-entry register file, the immediate extender, the ALU and both memories live inside the block. The instruction and data memories are word-indexed internal arrays that a test environment fills directly before reset is released.

Decoding happens in two stages. A main decoder looks only at the 6-bit opcode and produces the datapath steering plus a 3-bit ALU operation class. A small local decoder turns that class, together with the funct field for register-register instructions, into the 3-bit ALU command. The only outputs are debug taps: the current program counter and the register-file write that the current instruction performs.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active high. While it is high the program counter is held at 0 and no register or memory write takes place. In the first cycle after it falls the PC is still 0.
- R2: Instruction fields sit at op [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], immediate [15:0]. Every instruction other than a taken branch advances the PC by 4 in one clock.
- R3: Opcode 000000 is a register-register operation that writes R[rd]. Funct 100000 adds, 100010 subtracts (rs minus rt), 100100 ANDs and 100101 ORs R[rs] with R[rt].
- R4: Funct 100010 with opcode 000000 is subtract; funct 101010 writes 1 to R[rd] when R[rs] is less than R[rt] as two's-complement values, else 0.
- R5: Opcode 001101 writes R[rs] OR the zero-extended immediate to R[rt].
- R6: Opcode 100011 loads the data word at byte address R[rs] + sign-extended immediate into R[rt]. Opcode 101011 stores R[rt] at that address and writes no register. Memories are indexed by address bits [k+1:2].
- R7: Opcode 000100 compares R[rs] and R[rt]. When equal, the next PC is PC + 4 + (sign-extended immediate shifted left by 2), otherwise PC + 4. It writes no register.
- R8: Register 0 always reads as zero, and a write aimed at it is dropped and not shown on the write tap.
- R9: Any opcode outside the five above does nothing except advance the PC by 4.
- R10: In the same cycle as the instruction sits at the PC, the write tap shows the enable, destination index and data of the register write that takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction being executed |
| dbg_rf_we | output | 1 | High when the current instruction writes a nonzero register |
| dbg_rf_waddr | output | 5 | Register index being written |
| dbg_rf_wdata | output | 32 | Value being written |

## Verification
The bench builds the core with a 32-word instruction memory and a 16-word data memory rather than the 64-word defaults. With a smaller data memory the load and store index bits are a narrower slice of the byte address, so a negative-offset load that must land on the same word a store wrote shows whether the sign-extended offset and the word indexing agree. The short instruction store still holds a program that covers every opcode, a forward taken branch over two poison words, a not-taken branch and a branch that loops on itself.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XW = 32;
    localparam int RW = 5;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_ORIMM = 6'b001101;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BREQ  = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_cmd_e;

    typedef enum logic [2:0] {
        CLS_ADD   = 3'b000,
        CLS_SUB   = 3'b001,
        CLS_OR    = 3'b010,
        CLS_FUNCT = 3'b100
    } alu_cls_e;

    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } instr_t;

    typedef struct packed {
        logic     dst_is_rd;
        logic     b_from_imm;
        logic     wb_from_mem;
        logic     reg_we;
        logic     mem_we;
        logic     is_branch;
        logic     imm_signed;
        alu_cls_e alu_cls;
    } ctrl_t;

    function automatic logic [15:0] imm_field(input instr_t ins);
        return {ins.rd, ins.shamt, ins.funct};
    endfunction

    function automatic logic [XW-1:0] extend_imm(input logic [15:0] imm, input logic sgn);
        return sgn ? {{(XW-16){imm[15]}}, imm} : {{(XW-16){1'b0}}, imm};
    endfunction

    function automatic logic [XW-1:0] branch_dest(input logic [XW-1:0] seq_pc,
                                                  input logic [15:0] imm);
        return seq_pc + {{(XW-18){imm[15]}}, imm, 2'b00};
    endfunction

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] op,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{dst_is_rd: 1'b0, b_from_imm: 1'b0, wb_from_mem: 1'b0,
                 reg_we: 1'b0, mem_we: 1'b0, is_branch: 1'b0,
                 imm_signed: 1'b0, alu_cls: CLS_ADD};
        unique case (op)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.alu_cls   = CLS_FUNCT;
            end
            OPC_ORIMM: begin
                ctrl.b_from_imm = 1'b1;
                ctrl.reg_we     = 1'b1;
                ctrl.alu_cls    = CLS_OR;
            end
            OPC_LOAD: begin
                ctrl.b_from_imm  = 1'b1;
                ctrl.imm_signed  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_we      = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_from_imm = 1'b1;
                ctrl.imm_signed = 1'b1;
                ctrl.mem_we     = 1'b1;
            end
            OPC_BREQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_cls   = CLS_SUB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_cmd_e   cmd
);
    always_comb begin
        unique case (cls)
            CLS_SUB: cmd = ALU_SUB;
            CLS_OR:  cmd = ALU_OR;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_SUB:  cmd = ALU_SUB;
                    FN_AND:  cmd = ALU_AND;
                    FN_OR:   cmd = ALU_OR;
                    FN_SLT:  cmd = ALU_SLT;
                    default: cmd = ALU_ADD;
                endcase
            end
            default: cmd = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_cmd_e     cmd,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (cmd)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb,
    input  logic          we_req,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic          we_eff
);
    logic [W-1:0] regs [1:NREG-1];

    assign we_eff = we_req && (wa != '0);

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (we_eff && (wa == AW'(g))) regs[g] <= wd;
        end
    end

    assign qa = (ra == '0) ? '0 : regs[ra];
    assign qb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IA = $clog2(IMEM_WORDS),
    localparam int DA = $clog2(DMEM_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [XW-1:0] dbg_pc,
    output logic          dbg_rf_we,
    output logic [RW-1:0] dbg_rf_waddr,
    output logic [XW-1:0] dbg_rf_wdata
);
    logic [XW-1:0] imem [IMEM_WORDS];
    logic [XW-1:0] dmem [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
        for (int i = 0; i < DMEM_WORDS; i++) dmem[i] = '0;
    end

    logic [XW-1:0] pc, seq_pc, next_pc;
    instr_t        ir;
    ctrl_t         ctrl;
    alu_cmd_e      cmd;
    logic [XW-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, mem_q, wb;
    logic          alu_zero, rf_we_eff, mem_we;
    logic [RW-1:0] wa;

    assign ir = instr_t'(imem[pc[IA+1:2]]);

    sc_main_dec u_main (.op(ir.op), .ctrl(ctrl));

    sc_alu_dec u_adec (.cls(ctrl.alu_cls), .funct(ir.funct), .cmd(cmd));

    sc_regfile #(.W(XW), .NREG(1 << RW)) u_rf (
        .clk   (clk),
        .ra    (ir.rs),
        .rb    (ir.rt),
        .qa    (rs_val),
        .qb    (rt_val),
        .we_req(ctrl.reg_we && !rst),
        .wa    (wa),
        .wd    (wb),
        .we_eff(rf_we_eff)
    );

    assign imm_ext = extend_imm(imm_field(ir), ctrl.imm_signed);
    assign alu_b   = ctrl.b_from_imm ? imm_ext : rt_val;

    sc_alu #(.W(XW)) u_alu (.a(rs_val), .b(alu_b), .cmd(cmd), .y(alu_y), .zero(alu_zero));

    assign mem_we = ctrl.mem_we && !rst;
    assign mem_q  = dmem[alu_y[DA+1:2]];

    always_ff @(posedge clk) begin
        if (mem_we) dmem[alu_y[DA+1:2]] <= rt_val;
    end

    assign wb = ctrl.wb_from_mem ? mem_q : alu_y;
    assign wa = ctrl.dst_is_rd ? ir.rd : ir.rt;

    assign seq_pc  = pc + XW'(4);
    assign next_pc = (ctrl.is_branch && alu_zero) ? branch_dest(seq_pc, imm_field(ir)) : seq_pc;

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= next_pc;
    end

    assign dbg_pc       = pc;
    assign dbg_rf_we    = rf_we_eff;
    assign dbg_rf_waddr = wa;
    assign dbg_rf_wdata = wb;

    logic unused_bits;
    assign unused_bits = ^{pc[XW-1:IA+2], pc[1:0], alu_y[XW-1:DA+2], alu_y[1:0], ir.shamt};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] dbg_pc,
    input logic        dbg_rf_we,
    input logic [4:0]  dbg_rf_waddr,
    input logic [5:0]  op,
    input logic        mem_we
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    pc_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> dbg_pc == 32'd0);

    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_pc[1:0] == 2'b00);

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (op != 6'b000100) |=> dbg_pc == $past(dbg_pc) + 32'd4);

    // R8
    zero_reg_tap_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_rf_we |-> dbg_rf_waddr != 5'd0);

    // R6
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> op == 6'b101011);

    // R9
    unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op != 6'b000000 && op != 6'b001101 && op != 6'b100011 &&
         op != 6'b101011 && op != 6'b000100) |-> (!dbg_rf_we && !mem_we));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dbg_pc      (dbg_pc),
    .dbg_rf_we   (dbg_rf_we),
    .dbg_rf_waddr(dbg_rf_waddr),
    .op          (ir.op),
    .mem_we      (mem_we)
);

// File: tb/test_sc_core.sv
module test_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc;
    logic        dbg_rf_we;
    logic [4:0]  dbg_rf_waddr;
    logic [31:0] dbg_rf_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sc_core #(.IMEM_WORDS(32), .DMEM_WORDS(16)) i_sc_core (
        .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_rf_we(dbg_rf_we),
        .dbg_rf_waddr(dbg_rf_waddr), .dbg_rf_wdata(dbg_rf_wdata)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] ins;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{32'd0,  enc_i(6'h0D, 0, 1, 16'h0005),  1'b1, 5'd1,  32'h0000_0005}, // R5
        '{32'd4,  enc_i(6'h0D, 0, 2, 16'hFFFF),  1'b1, 5'd2,  32'h0000_FFFF}, // R5 zero-extend
        '{32'd8,  enc_r(1, 2, 3, 6'b100000),     1'b1, 5'd3,  32'h0001_0004}, // R3 add
        '{32'd12, enc_r(1, 2, 4, 6'b100010),     1'b1, 5'd4,  32'hFFFF_0006}, // R4 sub
        '{32'd16, enc_r(3, 2, 5, 6'b100100),     1'b1, 5'd5,  32'h0000_0004}, // R3 and
        '{32'd20, enc_r(1, 2, 6, 6'b100101),     1'b1, 5'd6,  32'h0000_FFFF}, // R3 or
        '{32'd24, enc_r(4, 1, 7, 6'b101010),     1'b1, 5'd7,  32'h0000_0001}, // R4 slt true
        '{32'd28, enc_r(1, 4, 8, 6'b101010),     1'b1, 5'd8,  32'h0000_0000}, // R4 slt false
        '{32'd32, enc_i(6'h2B, 0, 3, 16'h0008),  1'b0, 5'd0,  32'h0},         // R6 store
        '{32'd36, enc_i(6'h23, 0, 9, 16'h0008),  1'b1, 5'd9,  32'h0001_0004}, // R6 load
        '{32'd40, enc_i(6'h0D, 0, 10, 16'h000C), 1'b1, 5'd10, 32'h0000_000C}, // R5
        '{32'd44, enc_i(6'h23, 10, 11, 16'hFFFC),1'b1, 5'd11, 32'h0001_0004}, // R6 neg offset
        '{32'd48, enc_r(1, 1, 0, 6'b100000),     1'b0, 5'd0,  32'h0},         // R8 write r0
        '{32'd52, enc_r(0, 0, 12, 6'b100000),    1'b1, 5'd12, 32'h0000_0000}, // R8 read r0
        '{32'd56, enc_i(6'h04, 1, 2, 16'h0005),  1'b0, 5'd0,  32'h0},         // R7 not taken
        '{32'd60, enc_i(6'h04, 3, 11, 16'h0002), 1'b0, 5'd0,  32'h0},         // R7 taken fwd
        '{32'd72, 32'hFC22_1234,                 1'b0, 5'd0,  32'h0},         // R9 unknown
        '{32'd76, enc_i(6'h04, 0, 0, 16'hFFFF),  1'b0, 5'd0,  32'h0},         // R7 self loop
        '{32'd76, enc_i(6'h04, 0, 0, 16'hFFFF),  1'b0, 5'd0,  32'h0}          // R7 self loop
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        #1;
        i_sc_core.imem[16] = enc_i(6'h0D, 0, 13, 16'h0BAD);
        i_sc_core.imem[17] = enc_i(6'h0D, 0, 13, 16'h0BAD);
        for (int i = 0; i < NV; i++) i_sc_core.imem[VECS[i].pc >> 2] = VECS[i].ins;

        // R1: reset holds PC and blocks writes even though an ori sits at 0
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", dbg_pc, 32'd0);
        chk("R1 no write in reset", {31'd0, dbg_rf_we}, 32'd0);

        rst = 1'b0;
        #1;
        chk("R1 pc after release", dbg_pc, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (i != 0) begin
                @(negedge clk);
                #1;
            end
            chk("R2/R7 pc", dbg_pc, VECS[i].pc);
            chk("R10 we tap", {31'd0, dbg_rf_we}, {31'd0, VECS[i].we});
            if (VECS[i].we) begin
                chk("R10 waddr tap", {27'd0, dbg_rf_waddr}, {27'd0, VECS[i].wa});
                chk("R3/R4/R5/R6 wdata", dbg_rf_wdata, VECS[i].wd);
            end
        end

        // R1: reset asserted mid-run returns PC to 0 and suppresses writes
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 pc mid-run reset", dbg_pc, 32'd0);
        chk("R1 write gated", {31'd0, dbg_rf_we}, 32'd0);
        rst = 1'b0;
        #1;
        chk("R10 write after reset", {31'd0, dbg_rf_we}, 32'd1);
        chk("R5 data after reset", dbg_rf_wdata, 32'h0000_0005);
        @(negedge clk);
        #1;
        chk("R2 pc step", dbg_pc, 32'd4);

        done = 1'b1;
        finish_run();
    end

endmodule